// File: doc/BRIEF.md
# Raw Pixel Black Level, Gain and Test Bar Stage

This block is the first conditioning step for a raw colour pixel stream taken from a sensor that uses a paired-row Bayer mosaic. Every incoming pixel carries a valid strobe, a frame-start mark and a line-start mark. The block counts rows and columns from those marks and works out which of four colour sites the pixel occupies. It uses that colour to pick a per-site black level and a per-site digital gain.

The conditioning path has three steps. It subtracts the chosen black level and clamps the result at zero. It multiplies by the chosen gain, clamps gains below unity up to unity, and saturates the product at full scale. It then adds one shared black offset back, again saturating at full scale.

A configuration bit replaces the conditioned value with a test image of eight equal-width vertical bars that step from black to full scale across the active line. Results leave two clock cycles after the pixel enters, with a colour tag and delayed copies of the markers. A horizontal mirror bit swaps the column parity for sensors that read lines right to left.

Top module: `raw_cond_stage`

## Requirements
- R1: The colour tag is {row bit 1, column parity}. Code 0 is red (even row pair, even column), 1 is green on a red row pair (even pair, odd column), 2 is green on a blue row pair (odd pair, even column) and 3 is blue (odd pair, odd column). Within one line, green and non-green pixels alternate.
- R2: When `cfg_mirror` is 1, the column parity used for the colour tag is inverted.
- R3: A valid pixel with `in_sof` high is row 0, column 0. A valid pixel with only `in_sol` high is column 0 of the next row. Any other valid pixel is the next column of the same row. Cycles with `in_valid` low do not advance the counters.
- R4: The black level for the pixel's colour code c is `cfg_black_sub[c*PIX_W +: PIX_W]`. It is subtracted from the pixel, and results below zero become 0.
- R5: The gain for colour code c is `cfg_gain[c*GAIN_W +: GAIN_W]`, unsigned with GAIN_FRAC fraction bits (x1 = 32 by default). Gains below x1 act as exactly x1.
- R6: The gained value is floor(difference × gain / 2^GAIN_FRAC) and saturates at 2^PIX_W−1.
- R7: `cfg_black_add` is added after the gain, and the sum saturates at 2^PIX_W−1. A conditioned output is therefore never below `cfg_black_add`.
- R8: When `cfg_pattern` is 1, the output is bar level floor(b × (2^PIX_W−1) / 7). Here b = min(column / (ACTIVE_COLS/8), 7), using the unmirrored column, so columns past the last bar stay at full scale.
- R9: `out_valid` equals `in_valid` delayed by two clock cycles. `out_sof`, `out_sol`, `out_color` and `out_pix` belong to the same pixel.
- R10: While reset is active, `out_valid`, `out_sof`, `out_sol`, `out_color` and `out_pix` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input pixel strobe |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a line |
| in_pix | input | PIX_W | Raw pixel value |
| cfg_mirror | input | 1 | Invert column parity for colour decode |
| cfg_pattern | input | 1 | Select colour-bar test image |
| cfg_black_sub | input | 4*PIX_W | Per-colour black level to subtract |
| cfg_gain | input | 4*GAIN_W | Per-colour digital gain, fixed point |
| cfg_black_add | input | PIX_W | Offset added after gain |
| out_valid | output | 1 | Output pixel strobe |
| out_sof | output | 1 | Frame start, delayed |
| out_sol | output | 1 | Line start, delayed |
| out_color | output | 2 | Colour code of the output pixel |
| out_pix | output | PIX_W | Conditioned or test pixel |

## Verification
The bench builds the block with ACTIVE_COLS = 16, which makes each test bar two pixels wide. A single 20-pixel line then covers every bar edge and the clamp past the last bar. PIX_W, GAIN_W and GAIN_FRAC keep their default values of 10, 8 and 5. That keeps the real saturation points at 1023, the x1 clamp at 32 and the near-x8 gain of 255 in play. Separate gains and black levels per colour let the output value show whether the tag picked the right site. Frames are sent with and without mirroring and with idle gaps inside a line.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  // Colour code: bit 1 = odd row pair, bit 0 = odd (effective) column
  typedef enum logic [1:0] {
    CLR_R  = 2'd0,
    CLR_GR = 2'd1,
    CLR_GB = 2'd2,
    CLR_B  = 2'd3
  } color_e;

  localparam int BAR_COUNT = 8;
  localparam int NUM_SITES = 4;

  function automatic color_e site_of(input logic pair_odd, input logic col_odd);
    return color_e'({pair_odd, col_odd});
  endfunction

  function automatic logic is_green(input color_e c);
    return (c == CLR_GR) || (c == CLR_GB);
  endfunction

endpackage

// File: rtl/rcs_position.sv
module rcs_position
  import rcs_pkg::*;
#(
  parameter int COL_W = 11,
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_sol,
  input  logic             cfg_mirror,
  output logic [COL_W-1:0] cur_col,
  output color_e           cur_color
);

  logic [ROW_W-1:0] row_q, row_n;
  logic [COL_W-1:0] col_q, col_n;
  logic             green_q, have_q;
  logic             cur_green;

  // next-state: position of the pixel presented this cycle
  always_comb begin
    row_n = row_q;
    col_n = col_q + COL_W'(1);
    if (in_sof) begin
      row_n = '0;
      col_n = '0;
    end else if (in_sol) begin
      row_n = row_q + ROW_W'(1);
      col_n = '0;
    end
  end

  assign cur_col   = col_n;
  assign cur_color = site_of(row_n[1], col_n[0] ^ cfg_mirror);
  assign cur_green = is_green(cur_color);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      green_q <= 1'b0;
      have_q  <= 1'b0;
    end else if (in_valid) begin
      row_q   <= row_n;
      col_q   <= col_n;
      green_q <= cur_green;
      have_q  <= 1'b1;
    end
  end

  // R3: frame start puts the pixel at the origin
  a_r3_frame_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (row_q == '0 && col_q == '0));

  // R3: line start restarts the column count
  a_r3_line_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sol) |=> (col_q == '0));

  // R3: idle cycles hold the position
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid) |=> ($stable(col_q) && $stable(row_q)));

  // R1: within a line green and non-green sites alternate
  a_r1_green_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof && !in_sol && have_q && $stable(cfg_mirror))
      |-> (cur_green != green_q));

endmodule

// File: rtl/rcs_bar_gen.sv
module rcs_bar_gen
  import rcs_pkg::*;
#(
  parameter int PIX_W       = 10,
  parameter int COL_W       = 11,
  parameter int ACTIVE_COLS = 640
) (
  input  logic [COL_W-1:0] col,
  output logic [PIX_W-1:0] level
);

  localparam int BAR_WIDTH = ACTIVE_COLS / BAR_COUNT;
  localparam int IDX_W     = $clog2(BAR_COUNT);
  localparam int FULL      = (1 << PIX_W) - 1;

  logic [BAR_COUNT-2:0] edge_passed;
  logic [PIX_W-1:0]     lvl_tab [BAR_COUNT];
  logic [IDX_W-1:0]     bar_idx;

  // one threshold compare per bar boundary
  for (genvar k = 1; k < BAR_COUNT; k++) begin : g_edge
    assign edge_passed[k-1] = (col >= COL_W'(k * BAR_WIDTH));
  end

  // evenly spaced bar levels from black to full scale
  for (genvar k = 0; k < BAR_COUNT; k++) begin : g_lvl
    assign lvl_tab[k] = PIX_W'((k * FULL) / (BAR_COUNT - 1));
  end

  always_comb begin
    bar_idx = '0;
    for (int k = 0; k < BAR_COUNT - 1; k++) begin
      bar_idx = bar_idx + IDX_W'(edge_passed[k]);
    end
  end

  assign level = lvl_tab[bar_idx];

endmodule

// File: rtl/rcs_gain_unit.sv
module rcs_gain_unit #(
  parameter int PIX_W     = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 5
) (
  input  logic [PIX_W-1:0]  diff,
  input  logic [GAIN_W-1:0] gain,
  input  logic [PIX_W-1:0]  black_add,
  output logic [PIX_W-1:0]  result
);

  localparam int                UNITY  = 1 << GAIN_FRAC;
  localparam int                PROD_W = PIX_W + GAIN_W;
  localparam logic [PIX_W-1:0]  PMAX   = '1;

  logic [GAIN_W-1:0] gain_eff;
  logic [PROD_W-1:0] prod, scaled;
  logic [PIX_W-1:0]  gained;
  logic [PIX_W:0]    sum;

  always_comb begin
    gain_eff = (gain < GAIN_W'(UNITY)) ? GAIN_W'(UNITY) : gain;
    prod     = PROD_W'(diff) * PROD_W'(gain_eff);
    scaled   = prod >> GAIN_FRAC;
    gained   = (|scaled[PROD_W-1:PIX_W]) ? PMAX : scaled[PIX_W-1:0];
    sum      = {1'b0, gained} + {1'b0, black_add};
    result   = sum[PIX_W] ? PMAX : sum[PIX_W-1:0];
  end

endmodule

// File: rtl/raw_cond_stage.sv
module raw_cond_stage
  import rcs_pkg::*;
#(
  parameter int PIX_W       = 10,
  parameter int GAIN_W      = 8,
  parameter int GAIN_FRAC   = 5,
  parameter int COL_W       = 11,
  parameter int ROW_W       = 10,
  parameter int ACTIVE_COLS = 640
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_sof,
  input  logic                  in_sol,
  input  logic [PIX_W-1:0]      in_pix,
  input  logic                  cfg_mirror,
  input  logic                  cfg_pattern,
  input  logic [4*PIX_W-1:0]    cfg_black_sub,
  input  logic [4*GAIN_W-1:0]   cfg_gain,
  input  logic [PIX_W-1:0]      cfg_black_add,
  output logic                  out_valid,
  output logic                  out_sof,
  output logic                  out_sol,
  output logic [1:0]            out_color,
  output logic [PIX_W-1:0]      out_pix
);

  // reset: asynchronous assert, synchronous release
  logic rs_meta_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rst_i     <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rst_i     <= rs_meta_q;
    end
  end

  // position and colour of the current pixel
  logic [COL_W-1:0] cur_col;
  color_e           cur_color;

  rcs_position #(.COL_W(COL_W), .ROW_W(ROW_W)) u_pos (
    .clk       (clk),
    .rst_n     (rst_i),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_sol    (in_sol),
    .cfg_mirror(cfg_mirror),
    .cur_col   (cur_col),
    .cur_color (cur_color)
  );

  logic [PIX_W-1:0] bar_level;
  rcs_bar_gen #(.PIX_W(PIX_W), .COL_W(COL_W), .ACTIVE_COLS(ACTIVE_COLS)) u_bar (
    .col  (cur_col),
    .level(bar_level)
  );

  // stage 1: black subtraction per colour site
  logic [PIX_W-1:0] bsub_sel, diff_n;
  always_comb begin
    bsub_sel = cfg_black_sub[int'(cur_color)*PIX_W +: PIX_W];
    diff_n   = (in_pix > bsub_sel) ? (in_pix - bsub_sel) : '0;
  end

  logic             s1_valid_q, s1_sof_q, s1_sol_q, s1_pat_q;
  color_e           s1_color_q;
  logic [PIX_W-1:0] s1_diff_q, s1_bar_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      s1_valid_q <= 1'b0;
      s1_sof_q   <= 1'b0;
      s1_sol_q   <= 1'b0;
      s1_pat_q   <= 1'b0;
      s1_color_q <= CLR_R;
      s1_diff_q  <= '0;
      s1_bar_q   <= '0;
    end else begin
      s1_valid_q <= in_valid;
      s1_sof_q   <= in_valid & in_sof;
      s1_sol_q   <= in_valid & in_sol;
      if (in_valid) begin
        s1_pat_q   <= cfg_pattern;
        s1_color_q <= cur_color;
        s1_diff_q  <= diff_n;
        s1_bar_q   <= bar_level;
      end
    end
  end

  // stage 2: gain, offset, pattern select
  logic [GAIN_W-1:0] gain_sel;
  logic [PIX_W-1:0]  cond_pix, pix_n;

  assign gain_sel = cfg_gain[int'(s1_color_q)*GAIN_W +: GAIN_W];

  rcs_gain_unit #(.PIX_W(PIX_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_gain (
    .diff     (s1_diff_q),
    .gain     (gain_sel),
    .black_add(cfg_black_add),
    .result   (cond_pix)
  );

  assign pix_n = s1_pat_q ? s1_bar_q : cond_pix;

  logic s2_pat_q;
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_sol   <= 1'b0;
      out_color <= 2'd0;
      out_pix   <= '0;
      s2_pat_q  <= 1'b0;
    end else begin
      out_valid <= s1_valid_q;
      out_sof   <= s1_sof_q;
      out_sol   <= s1_sol_q;
      if (s1_valid_q) begin
        out_color <= s1_color_q;
        out_pix   <= pix_n;
        s2_pat_q  <= s1_pat_q;
      end
    end
  end

  // cycles since reset release, for the latency check
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R9: two-cycle latency of the valid strobe
  a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_i)
    (warm_q >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R9: markers only with a valid pixel
  a_r9_marks_with_valid: assert property (@(posedge clk) disable iff (!rst_i)
    (out_sof || out_sol) |-> out_valid);

  // R7: conditioned output never drops below the added offset
  a_r7_offset_floor: assert property (@(posedge clk) disable iff (!rst_i)
    (out_valid && !s2_pat_q && $stable(cfg_black_add)) |-> (out_pix >= cfg_black_add));

endmodule

// File: tb/tb_raw_cond_stage.sv
`timescale 1ns/1ps
module tb_raw_cond_stage;

  localparam int PW = 10;
  localparam int GW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_sof, in_sol;
  logic [PW-1:0] in_pix;
  logic          cfg_mirror, cfg_pattern;
  logic [4*PW-1:0] cfg_black_sub;
  logic [4*GW-1:0] cfg_gain;
  logic [PW-1:0] cfg_black_add;
  logic          out_valid, out_sof, out_sol;
  logic [1:0]    out_color;
  logic [PW-1:0] out_pix;

  always #2.5 clk = ~clk;

  raw_cond_stage #(.ACTIVE_COLS(16)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol), .in_pix(in_pix),
    .cfg_mirror(cfg_mirror), .cfg_pattern(cfg_pattern),
    .cfg_black_sub(cfg_black_sub), .cfg_gain(cfg_gain), .cfg_black_add(cfg_black_add),
    .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
    .out_color(out_color), .out_pix(out_pix)
  );

  int total = 0, fails = 0;
  bit done = 0;

  // {black_sub, gain, black_add, pixel, expected} on the red site
  localparam logic [47:0] VEC [12] = '{
    {10'd0,   8'd32,  10'd0,  10'd500,  10'd500 },
    {10'd64,  8'd32,  10'd0,  10'd50,   10'd0   },
    {10'd64,  8'd64,  10'd0,  10'd564,  10'd1000},
    {10'd0,   8'd64,  10'd0,  10'd600,  10'd1023},
    {10'd0,   8'd16,  10'd0,  10'd300,  10'd300 },
    {10'd0,   8'd255, 10'd0,  10'd100,  10'd796 },
    {10'd10,  8'd48,  10'd0,  10'd111,  10'd151 },
    {10'd0,   8'd32,  10'd40, 10'd1000, 10'd1023},
    {10'd100, 8'd32,  10'd40, 10'd50,   10'd40  },
    {10'd0,   8'd0,   10'd0,  10'd7,    10'd7   },
    {10'd0,   8'd255, 10'd0,  10'd1023, 10'd1023},
    {10'd20,  8'd40,  10'd5,  10'd420,  10'd505 }
  };

  int cap_n = 0, exp_n = 0;
  int cap_col [64], cap_pix [64], cap_mk [64];
  int exp_col [64], exp_pix [64], exp_mk [64];

  always @(negedge clk) begin
    if (rst_n && out_valid && cap_n < 64) begin
      cap_col[cap_n] = int'(out_color);
      cap_pix[cap_n] = int'(out_pix);
      cap_mk[cap_n]  = int'({out_sof, out_sol});
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int model(int p, int bs, int g, int ba);
    int d, ge, m;
    d  = (p > bs) ? p - bs : 0;
    ge = (g < 32) ? 32 : g;
    m  = (d * ge) / 32;
    if (m > 1023) m = 1023;
    m  = m + ba;
    if (m > 1023) m = 1023;
    return m;
  endfunction

  function automatic int bar_of(int c);
    int b;
    b = c / 2;
    if (b > 7) b = 7;
    return (b * 1023) / 7;
  endfunction

  task automatic put(input bit sof, input bit sol, input int r, input int c, input int v);
    int ch;
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; in_sol = sol; in_pix = PW'(v);
    ch = (((r >> 1) & 1) << 1) | ((c & 1) ^ int'(cfg_mirror));
    exp_col[exp_n] = ch;
    exp_pix[exp_n] = cfg_pattern ? bar_of(c)
                   : model(v, int'(cfg_black_sub[ch*PW +: PW]), int'(cfg_gain[ch*GW +: GW]),
                           int'(cfg_black_add));
    exp_mk[exp_n]  = (int'(sof) << 1) | int'(sol);
    exp_n++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
  endtask

  task automatic check_stream(input string tag);
    repeat (4) @(negedge clk);
    chk(cap_n == exp_n, "R9 count", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      chk(cap_col[i] == exp_col[i], tag, cap_col[i], exp_col[i]);
      chk(cap_pix[i] == exp_pix[i], tag, cap_pix[i], exp_pix[i]);
      chk(cap_mk[i] == exp_mk[i], "R9 markers", cap_mk[i], exp_mk[i]);
    end
    cap_n = 0; exp_n = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0; in_pix = '0;
    cfg_mirror = 1'b0; cfg_pattern = 1'b0;
    cfg_black_sub = '0; cfg_gain = {4{8'd32}}; cfg_black_add = '0;
    repeat (3) @(negedge clk);
    // R10: outputs cleared under reset
    chk(out_valid == 1'b0 && out_sof == 1'b0 && out_sol == 1'b0, "R10 flags",
        int'({out_valid, out_sof, out_sol}), 0);
    chk(out_pix == '0 && out_color == 2'd0, "R10 data", int'(out_pix), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R10 idle after release", int'(out_valid), 0);

    // vector table: R4 R5 R6 R7 arithmetic on the red site
    for (int i = 0; i < 12; i++) begin
      cfg_black_sub[PW-1:0] = VEC[i][47:38];
      cfg_gain[GW-1:0]      = VEC[i][37:30];
      cfg_black_add         = VEC[i][29:20];
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b1; in_sol = 1'b1; in_pix = VEC[i][19:10];
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b1, "R9 latency", int'(out_valid), 1);
      chk(out_pix == VEC[i][9:0], "R4 R5 R6 R7", int'(out_pix), int'(VEC[i][9:0]));
    end
    repeat (3) @(negedge clk);
    cap_n = 0; exp_n = 0;

    // per-site settings: R1 R3 R4 decode with idle gap inside a line
    cfg_black_add = '0;
    cfg_black_sub = {10'd10, 10'd0, 10'd0, 10'd0};
    cfg_gain      = {8'd128, 8'd96, 8'd64, 8'd32};
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        put(r == 0 && c == 0, c == 0, r, c, 100 + r * 7 + c * 3);
        if (r == 1 && c == 1) begin idle(); idle(); end
      end
    end
    idle();
    check_stream("R1 R3 R4");

    // mirrored frame, new frame start resets the row: R2 R3
    cfg_mirror = 1'b1;
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 3; c++) begin
        put(r == 0 && c == 0, c == 0, r, c, 200 + r * 11 + c * 5);
      end
    end
    idle();
    check_stream("R2 R3");

    // colour bars across one line: R8
    cfg_mirror  = 1'b0;
    cfg_pattern = 1'b1;
    for (int c = 0; c < 20; c++) put(c == 0, c == 0, 0, c, 5);
    idle();
    check_stream("R8");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule